// File: doc/BRIEF.md
# Receive FIFO Flow-Control Hysteresis

This block drives an active-low request-to-send line from the fill count of a receive FIFO. A low line invites the remote end to keep sending. A high line asks it to stop. The block uses two thresholds, an upper one that stops the sender and a lower one that lets it resume, so the line does not toggle on every character.

A 2-bit table select picks one of four tables of four receive trigger levels, and a 2-bit trigger select picks a level inside that table. Tables A, B and C take their thresholds from the neighbouring entries of the chosen table. Table D instead applies a symmetric band of plus or minus a programmable number of characters around the chosen trigger. An enable input turns flow control off, and any change of the table, trigger or band setting restarts the evaluation from the asserted state. The FIFO itself is outside the block: only its fill count comes in.

Top module: `rx_rts_hysteresis`

## Requirements
- R1: While reset is high and on the first cycle after it, `rts_n_o` is 0 (asserted).
- R2: When `en_i` is 0 at a rising edge, `rts_n_o` is 0 after that edge, whatever the fill count.
- R3: Tables A–C (`tbl_sel_i` 0, 1, 2) hold trigger levels A = {8,16,24,28}, B = {8,16,32,56}, C = {8,16,56,60}, indexed by `trig_sel_i` 0..3. The upper threshold is the entry one index above the selected one, or 64 for index 3. `rts_n_o` goes to 1 when the fill is at or above it.
- R4: For tables A–C the lower threshold is the entry one index below the selected one, or 0 for index 0. `rts_n_o` goes to 0 when the fill is at or below it and below the upper threshold. For example, table C with trigger 56 stops the sender at 60 and resumes it at 16.
- R5: When the fill is strictly between the two thresholds, `rts_n_o` keeps its previous value.
- R6: Table D (`tbl_sel_i` = 3) holds triggers {16,32,40,48} and a band of 4 × `hyst_code_i` characters (so 12 through 52 are among the settings). The upper threshold is min(trigger + band, 64) and the lower one is max(trigger − band, 0). These thresholds are applied as in R3 to R5.
- R7: A change of any bit of `tbl_sel_i`, `trig_sel_i` or `hyst_code_i` against its value at the previous edge forces `rts_n_o` to 0 for one cycle. Normal evaluation resumes from the next edge.
- R8: `rts_n_o` is registered and reflects the inputs sampled at the most recent rising edge.
- R9: When the upper and lower thresholds coincide and the fill equals them, stopping the sender wins and `rts_n_o` goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Flow-control enable |
| tbl_sel_i | input | 2 | Trigger table select (3 = hysteresis band mode) |
| trig_sel_i | input | 2 | Receive trigger index within the table |
| hyst_code_i | input | 4 | Band code; band = 4 × code characters |
| fill_i | input | 7 | Receive FIFO fill count, 0..64 |
| rts_n_o | output | 1 | Request-to-send, active low |

## Verification
Every result of this block appears one rising edge after the inputs that cause it. This holds for the threshold decisions, the enable override and the forced assertion on a setting change. The bench drives each input vector on a falling edge and lets one rising edge pass. It then compares `rts_n_o` at the following falling edge with a reference built from the requirement tables, and that reference steps its own hysteresis state once per vector. Directed vectors walk the table C example across 60 and 16, the saturated top and bottom entries, the band clamped at 64 and the coinciding thresholds. A seeded random walk of fill counts with occasional setting and enable changes covers the rest.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [1:0] {
    RFC_TBL_A = 2'd0,
    RFC_TBL_B = 2'd1,
    RFC_TBL_C = 2'd2,
    RFC_TBL_D = 2'd3
  } rfc_tbl_e;

  typedef struct packed {
    logic [1:0] tbl;
    logic [1:0] trig;
    logic [3:0] hyst;
  } rfc_cfg_t;

  // Trigger levels expressed for a 64-entry FIFO.
  function automatic int unsigned rfc_lvl64(input logic [1:0] tbl, input logic [1:0] idx);
    case ({tbl, idx})
      4'h0: return 8;   4'h1: return 16;  4'h2: return 24;  4'h3: return 28;
      4'h4: return 8;   4'h5: return 16;  4'h6: return 32;  4'h7: return 56;
      4'h8: return 8;   4'h9: return 16;  4'hA: return 56;  4'hB: return 60;
      4'hC: return 16;  4'hD: return 32;  4'hE: return 40;  default: return 48;
    endcase
  endfunction

  function automatic int unsigned rfc_scale(input int unsigned num, input int unsigned depth);
    return (num * depth) / 64;
  endfunction

  function automatic int unsigned rfc_sat_add(input int unsigned a, input int unsigned b,
                                              input int unsigned ceil);
    return (a + b > ceil) ? ceil : a + b;
  endfunction

  function automatic int unsigned rfc_sat_sub(input int unsigned a, input int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

endpackage

// File: rtl/rfc_thresh.sv
module rfc_thresh
  import rfc_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       tbl_i,
  input  logic [1:0]       trig_i,
  input  logic [3:0]       hyst_i,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] lo_o
);

  localparam int unsigned NLVL = 4;

  logic [CNT_W-1:0] lvl [NLVL];
  logic [CNT_W-1:0] trig_lvl;
  logic [CNT_W-1:0] band;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign lvl[g] = CNT_W'(rfc_scale(rfc_lvl64(tbl_i, 2'(g)), DEPTH));
  end

  assign trig_lvl = lvl[trig_i];
  assign band     = CNT_W'(rfc_scale(32'(hyst_i) * 32'd4, DEPTH));

  always_comb begin
    if (tbl_i == RFC_TBL_D) begin
      hi_o = CNT_W'(rfc_sat_add(32'(trig_lvl), 32'(band), DEPTH));
      lo_o = CNT_W'(rfc_sat_sub(32'(trig_lvl), 32'(band)));
    end else begin
      hi_o = (trig_i == 2'd3) ? CNT_W'(DEPTH) : lvl[trig_i + 2'd1];
      lo_o = (trig_i == 2'd0) ? '0 : lvl[trig_i - 2'd1];
    end
  end

endmodule

// File: rtl/rfc_rts_ctrl.sv
module rfc_rts_ctrl
  import rfc_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  rfc_cfg_t         cfg_i,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             rts_n_o
);

  rfc_cfg_t cfg_q;
  logic     rts_q;

  // Named events for the checks below.
  logic cfg_change;
  logic stop_hit;
  logic go_hit;

  assign cfg_change = (cfg_i != cfg_q);
  assign stop_hit   = (fill_i >= hi_i);
  assign go_hit     = (fill_i <= lo_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q <= '0;
      rts_q <= 1'b0;
    end else begin
      cfg_q <= cfg_i;
      if (!en_i || cfg_change) rts_q <= 1'b0;
      else if (stop_hit)       rts_q <= 1'b1;
      else if (go_hit)         rts_q <= 1'b0;
    end
  end

  assign rts_n_o = rts_q;

  AST_RESET_ASSERTED: assert property (@(posedge clk_i) rst_i |=> !rts_n_o); // R1
  AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> !rts_n_o); // R2
  AST_STOP_AT_UPPER: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !cfg_change && stop_hit) |=> rts_n_o); // R3
  AST_GO_AT_LOWER: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !cfg_change && go_hit && !stop_hit) |=> !rts_n_o); // R4
  AST_HOLD_IN_BAND: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !cfg_change && !go_hit && !stop_hit) |=> $stable(rts_n_o)); // R5
  AST_HI_CEIL: assert property (@(posedge clk_i) disable iff (rst_i)
    hi_i <= CNT_W'(DEPTH)); // R6
  AST_LO_LE_HI: assert property (@(posedge clk_i) disable iff (rst_i)
    lo_i <= hi_i); // R6
  AST_CFG_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
    cfg_change |=> !rts_n_o); // R7
  AST_TIE_STOPS: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !cfg_change && go_hit && stop_hit) |=> rts_n_o); // R9

endmodule

// File: rtl/rx_rts_hysteresis.sv
module rx_rts_hysteresis
  import rfc_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [1:0]       tbl_sel_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [3:0]       hyst_code_i,
  input  logic [CNT_W-1:0] fill_i,
  output logic             rts_n_o
);

  rfc_cfg_t         cfg;
  logic [CNT_W-1:0] hi;
  logic [CNT_W-1:0] lo;

  assign cfg.tbl  = tbl_sel_i;
  assign cfg.trig = trig_sel_i;
  assign cfg.hyst = hyst_code_i;

  rfc_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_thresh (
    .tbl_i  (tbl_sel_i),
    .trig_i (trig_sel_i),
    .hyst_i (hyst_code_i),
    .hi_o   (hi),
    .lo_o   (lo)
  );

  rfc_rts_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .cfg_i   (cfg),
    .fill_i  (fill_i),
    .hi_i    (hi),
    .lo_i    (lo),
    .rts_n_o (rts_n_o)
  );

endmodule

// File: tb/rx_rts_hysteresis_bench.sv
module rx_rts_hysteresis_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic [1:0] tbl;
  logic [1:0] trig;
  logic [3:0] hyst;
  logic [6:0] fill;
  logic       rts_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference state
  bit         m_rts;
  logic [7:0] m_cfg;

  always #5 clk = ~clk;

  rx_rts_hysteresis u_rx_rts_hysteresis (
    .clk_i(clk), .rst_i(rst), .en_i(en), .tbl_sel_i(tbl), .trig_sel_i(trig),
    .hyst_code_i(hyst), .fill_i(fill), .rts_n_o(rts_n)
  );

  function automatic int ref_level(int t, int i);
    int lv [4][4] = '{'{8, 16, 24, 28}, '{8, 16, 32, 56},
                      '{8, 16, 56, 60}, '{16, 32, 40, 48}};
    return lv[t][i];
  endfunction

  function automatic int ref_upper(int t, int i, int code);
    int v;
    if (t == 3) begin
      v = ref_level(t, i) + 4 * code;
      return (v > 64) ? 64 : v;
    end
    return (i == 3) ? 64 : ref_level(t, i + 1);
  endfunction

  function automatic int ref_lower(int t, int i, int code);
    int v;
    if (t == 3) begin
      v = ref_level(t, i) - 4 * code;
      return (v < 0) ? 0 : v;
    end
    return (i == 0) ? 0 : ref_level(t, i - 1);
  endfunction

  task automatic check(bit got, bit exp, string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: rts_n=%0b expected %0b (tbl=%0d trig=%0d hyst=%0d fill=%0d)",
               req, got, exp, tbl, trig, hyst, fill);
    end
  endtask

  // Applies one vector at a falling edge; R8: the result is due after the
  // next rising edge and is sampled at the falling edge that follows it.
  task automatic step(bit e, int t, int i, int c, int f);
    int    hi, lo;
    bit    exp;
    string req;
    logic [7:0] cfg;
    en = e; tbl = 2'(t); trig = 2'(i); hyst = 4'(c); fill = 7'(f);
    cfg = {2'(t), 2'(i), 4'(c)};
    hi  = ref_upper(t, i, c);
    lo  = ref_lower(t, i, c);
    if (!e)                begin exp = 0; req = "R2"; end
    else if (cfg != m_cfg) begin exp = 0; req = "R7"; end
    else if (f >= hi)      begin exp = 1; req = (hi == lo) ? "R9" : "R3"; end
    else if (f <= lo)      begin exp = 0; req = "R4"; end
    else                   begin exp = m_rts; req = "R5"; end
    if (t == 3 && e && cfg == m_cfg) req = {"R6/", req};
    req = {req, " (R8 one-edge latency)"};
    m_rts = exp;
    m_cfg = cfg;
    @(posedge clk);
    @(negedge clk);
    check(rts_n, exp, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got hang expected completion");
    finish_run();
  end

  initial begin
    int cur_fill, cur_t, cur_i, cur_c;
    bit cur_en;
    void'($urandom(32'h0001_5eed));
    rst = 1; en = 1; tbl = 2'd2; trig = 2'd2; hyst = 0; fill = 7'd64;
    m_rts = 0; m_cfg = 8'h00;
    repeat (3) @(negedge clk);
    check(rts_n, 1'b0, "R1 reset");
    rst = 0; tbl = 0; trig = 0; hyst = 0; fill = 0;
    @(posedge clk); @(negedge clk);
    check(rts_n, 1'b0, "R1 first cycle after reset");

    // R2: disabled with a full FIFO
    step(0, 0, 0, 0, 64);
    // R7 then R5/R3/R4 on the table C example: stop at 60, resume at 16
    step(1, 2, 2, 0, 59);
    step(1, 2, 2, 0, 59);
    step(1, 2, 2, 0, 60);
    step(1, 2, 2, 0, 40);
    step(1, 2, 2, 0, 17);
    step(1, 2, 2, 0, 16);
    step(1, 2, 2, 0, 59);
    // Top entry: stop only when full (R3), resume at 56 (R4)
    step(1, 2, 3, 0, 63);
    step(1, 2, 3, 0, 63);
    step(1, 2, 3, 0, 64);
    step(1, 2, 3, 0, 57);
    step(1, 2, 3, 0, 56);
    // Bottom entry of table A: resume only when empty (R4)
    step(1, 0, 0, 0, 16);
    step(1, 0, 0, 0, 16);
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0);
    // R2 overrides a stopped sender
    step(1, 1, 1, 0, 40);
    step(1, 1, 1, 0, 40);
    step(0, 1, 1, 0, 40);
    // R6: band 52 around 40 clamps to 64 / 0
    step(1, 3, 2, 13, 63);
    step(1, 3, 2, 13, 63);
    step(1, 3, 2, 13, 64);
    step(1, 3, 2, 13, 1);
    step(1, 3, 2, 13, 0);
    // R6: band 12 around 40 -> 52 / 28
    step(1, 3, 2, 3, 51);
    step(1, 3, 2, 3, 52);
    step(1, 3, 2, 3, 29);
    step(1, 3, 2, 3, 28);
    // R9: zero band, thresholds coincide at 40
    step(1, 3, 2, 0, 39);
    step(1, 3, 2, 0, 39);
    step(1, 3, 2, 0, 40);
    // R7: a band change alone restarts, even with a full FIFO
    step(1, 3, 2, 1, 64);
    step(1, 3, 2, 1, 64);

    // Constrained random walk
    cur_fill = 32; cur_t = 2; cur_i = 1; cur_c = 5; cur_en = 1;
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(39) == 0) begin
        cur_t = $urandom_range(3); cur_i = $urandom_range(3); cur_c = $urandom_range(15);
      end
      if ($urandom_range(49) == 0) cur_en = ~cur_en;
      if ($urandom_range(59) == 0) cur_fill = $urandom_range(64);
      else cur_fill = cur_fill + $urandom_range(10) - 5;
      if (cur_fill < 0)  cur_fill = 0;
      if (cur_fill > 64) cur_fill = 64;
      step(cur_en, cur_t, cur_i, cur_c, cur_fill);
    end
    finish_run();
  end

endmodule